// File: doc/BRIEF.md
# TPM FIFO Locality Command Sequencer

This block tracks the command and response life cycle of one locality of a TPM register interface built around a byte FIFO. It receives status-register writes and data-byte strobes that a bus decoder has already decoded. It also receives a "response ready" event and a "selftest done" event from the command engine side. From these it keeps a five-state sequence and a 32-bit status word. It raises single-cycle pulses for the command-ready interrupt, the status-valid interrupt, an execute request, a cancel request and a reset-establishment request.

Host software writes the command-ready bit, streams command bytes and writes the go bit. It then waits for the response, reads the response bytes and may ask for them again with the retry bit. The sequencer does not store command bytes. It counts them and decodes the 32-bit command length from the header so that it can tell when a packet is complete.

Top module: `tpm_loc_seq`

## Requirements
- R1: Reset is synchronous and active low. After reset the state output is IDLE and no pulse output is high. The state codes are IDLE=0, READY=1, RECEPTION=2, EXECUTION=3 and COMPLETION=4. The status word is zero apart from the family field.
- R2: Every status update keeps only bit 2 (selftest done) and bits 27:26 (family). It then sets the new flags. The flags are valid = bit 7 (0x80), command ready = bit 6 (0x40), data available = bit 4 (0x10) and expect = bit 3 (0x08).
- R3: A command-ready write (written value 0x40) moves IDLE to READY, gives status 0x40 and pulses `irq_cmd_ready`. The same write in RECEPTION or COMPLETION also returns to READY with status 0x40 and the pulse, and it clears the byte counts.
- R4: The first data byte accepted in READY moves to RECEPTION with status 0x88 (expect and valid).
- R5: Header bytes 2 to 5 hold the command length, most significant byte first. Once at least 6 bytes have been received and the count has reached the length, the status becomes 0x80. Before that it stays 0x88. If `CMD_MAX` bytes are already held, the next byte is dropped and the status becomes 0x80.
- R6: A go write (value 0x20) in RECEPTION with expect clear moves to EXECUTION and pulses `exec_req`. With expect still set the write is ignored.
- R7: `rsp_ready` in EXECUTION moves to COMPLETION, loads the response length and gives status 0x90 (valid and data available). In any other state it is ignored.
- R8: Each `data_rd` in COMPLETION with data available consumes one response byte. The read that reaches the response length sets the status to 0x80 and pulses `irq_sts_valid`. Later reads have no effect.
- R9: A retry write (value 0x02) in COMPLETION rewinds the read count and restores status 0x90. In other states it has no effect.
- R10: `selftest_done` sets status bit 2. The bit survives every later status update and is cleared only by reset.
- R11: The family field, bits 27:26, is loaded at reset from `tpm2_mode`: 01 for the newer TPM family and 00 for the older one. It never changes between resets.
- R12: With the family field at 01 and the state EXECUTION, a write with bit 24 set pulses `cancel_req`. No other case pulses it.
- R13: With the family field at 01, a write with bit 25 set pulses `rst_est_req` only when `req_loc` is 3 or 4.
- R14: Status and data writes from a locality that differs from `active_loc` are ignored. A status write that sets more than one of bits 6, 5 and 1 causes no state transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tpm2_mode | input | 1 | Selects the family value loaded at reset |
| active_loc | input | 3 | Locality that currently owns the interface |
| req_loc | input | 3 | Locality that issues the current access |
| sts_wr | input | 1 | Status register write strobe |
| sts_wdata | input | 32 | Status register write value |
| data_wr | input | 1 | Command byte write strobe |
| data_wbyte | input | 8 | Command byte |
| data_rd | input | 1 | Response byte consume strobe |
| rsp_ready | input | 1 | Response available event |
| rsp_len | input | 16 | Response length in bytes, sampled with rsp_ready |
| selftest_done | input | 1 | Selftest completion event |
| sts | output | 32 | Status word |
| state | output | 3 | Sequence state code |
| irq_cmd_ready | output | 1 | Command-ready interrupt pulse |
| irq_sts_valid | output | 1 | Status-valid interrupt pulse |
| exec_req | output | 1 | Execute request pulse |
| cancel_req | output | 1 | Cancel request pulse |
| rst_est_req | output | 1 | Reset-establishment request pulse |

## Verification
Every input event is registered, so a wrong internal state shows on `state` or `sts` one clock after the event that caused it. A byte count that is off by one moves the cycle in which expect clears, or the read on which `irq_sts_valid` fires, and that shows up at the exact byte where the checks sample. A lost sticky bit or a corrupted family field shows up at the very next status update, which reloads the word. Gating errors appear as a pulse or a transition that should not happen, on the cycle right after the offending write.

// File: rtl/tpm_seq_pkg.sv
package tpm_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_READY = 3'd1,
        ST_RECV  = 3'd2,
        ST_EXEC  = 3'd3,
        ST_DONE  = 3'd4
    } seq_state_e;

    localparam int unsigned B_VALID  = 7;
    localparam int unsigned B_CMDRDY = 6;
    localparam int unsigned B_GO     = 5;
    localparam int unsigned B_AVAIL  = 4;
    localparam int unsigned B_EXPECT = 3;
    localparam int unsigned B_STDONE = 2;
    localparam int unsigned B_RETRY  = 1;
    localparam int unsigned B_CANCEL = 24;
    localparam int unsigned B_RSTEST = 25;
    localparam int unsigned B_FAM_LO = 26;

    localparam logic [31:0] F_VALID  = 32'(1) << B_VALID;
    localparam logic [31:0] F_CMDRDY = 32'(1) << B_CMDRDY;
    localparam logic [31:0] F_AVAIL  = 32'(1) << B_AVAIL;
    localparam logic [31:0] F_EXPECT = 32'(1) << B_EXPECT;
    localparam logic [31:0] KEEP_MASK = (32'(1) << B_STDONE) | (32'(3) << B_FAM_LO);

    // the header holds a 32-bit length in bytes 2..5, most significant first
    localparam int unsigned HDR_BYTES = 6;

    function automatic logic [31:0] sts_merge(input logic [31:0] cur, input logic [31:0] flags);
        return (cur & KEEP_MASK) | flags;
    endfunction

endpackage

// File: rtl/tpm_sts_decode.sv
module tpm_sts_decode #(
    parameter int unsigned LOC_W = 3
) (
    input  logic             wr_en,
    input  logic [31:0]      wdata,
    input  logic [LOC_W-1:0] req_loc,
    input  logic [LOC_W-1:0] active_loc,
    input  logic             fam_new,
    input  logic             in_exec,
    output logic             do_cmdrdy,
    output logic             do_go,
    output logic             do_retry,
    output logic             do_cancel,
    output logic             do_rstest
);
    import tpm_seq_pkg::*;

    logic       permit_w;
    logic [2:0] sel_w;
    logic       upper_loc_w;
    logic       unused_bits;

    assign unused_bits = ^{wdata[31:26], wdata[23:7], wdata[4:2], wdata[0]};

    always_comb begin
        permit_w    = wr_en && (req_loc == active_loc);
        sel_w       = {wdata[B_CMDRDY], wdata[B_GO], wdata[B_RETRY]};
        upper_loc_w = (req_loc == LOC_W'(3)) || (req_loc == LOC_W'(4));
        do_cmdrdy   = permit_w && (sel_w == 3'b100);
        do_go       = permit_w && (sel_w == 3'b010);
        do_retry    = permit_w && (sel_w == 3'b001);
        do_cancel   = permit_w && fam_new && in_exec && wdata[B_CANCEL];
        do_rstest   = permit_w && fam_new && upper_loc_w && wdata[B_RSTEST];
    end

endmodule

// File: rtl/tpm_hdr_len.sv
module tpm_hdr_len #(
    parameter int unsigned CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             byte_en,
    input  logic [7:0]       byte_val,
    input  logic [CNT_W-1:0] byte_idx,
    output logic [31:0]      len_now
);
    logic [31:0] len_d, len_q;

    always_comb begin
        len_d = len_q;
        if (clr) begin
            len_d = '0;
        end else if (byte_en) begin
            case (byte_idx)
                CNT_W'(2): len_d[31:24] = byte_val;
                CNT_W'(3): len_d[23:16] = byte_val;
                CNT_W'(4): len_d[15:8]  = byte_val;
                CNT_W'(5): len_d[7:0]   = byte_val;
                default:   len_d        = len_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) len_q <= '0;
        else        len_q <= len_d;
    end

    // the length seen by the sequencer already includes the byte of this cycle
    assign len_now = len_d;

endmodule

// File: rtl/tpm_loc_seq.sv
module tpm_loc_seq #(
    parameter int unsigned NUM_LOC = 5,
    parameter int unsigned CMD_MAX = 64,
    parameter int unsigned RLEN_W  = 16,
    localparam int unsigned LOC_W  = $clog2(NUM_LOC),
    localparam int unsigned CNT_W  = $clog2(CMD_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tpm2_mode,
    input  logic [LOC_W-1:0]  active_loc,
    input  logic [LOC_W-1:0]  req_loc,
    input  logic              sts_wr,
    input  logic [31:0]       sts_wdata,
    input  logic              data_wr,
    input  logic [7:0]        data_wbyte,
    input  logic              data_rd,
    input  logic              rsp_ready,
    input  logic [RLEN_W-1:0] rsp_len,
    input  logic              selftest_done,
    output logic [31:0]       sts,
    output logic [2:0]        state,
    output logic              irq_cmd_ready,
    output logic              irq_sts_valid,
    output logic              exec_req,
    output logic              cancel_req,
    output logic              rst_est_req
);
    import tpm_seq_pkg::*;

    typedef struct packed {
        seq_state_e        state;
        logic [31:0]       sts;
        logic [CNT_W-1:0]  wr_cnt;
        logic [RLEN_W-1:0] rd_off;
        logic [RLEN_W-1:0] rlen;
        logic              irq_cr;
        logic              irq_sv;
        logic              exec;
        logic              cancel;
        logic              rstest;
    } seq_t;

    seq_t d, q, rst_val;

    logic loc_ok, dat_ok, store_w, rd_ok, cr_take, rsp_take, need_irq;
    logic dec_cmdrdy, dec_go, dec_retry, dec_cancel, dec_rstest;
    logic [31:0]      len_now;
    logic [CNT_W-1:0] cnt_inc;

    tpm_sts_decode #(.LOC_W(LOC_W)) i_dec (
        .wr_en      (sts_wr),
        .wdata      (sts_wdata),
        .req_loc    (req_loc),
        .active_loc (active_loc),
        .fam_new    (q.sts[B_FAM_LO+1:B_FAM_LO] == 2'b01),
        .in_exec    (q.state == ST_EXEC),
        .do_cmdrdy  (dec_cmdrdy),
        .do_go      (dec_go),
        .do_retry   (dec_retry),
        .do_cancel  (dec_cancel),
        .do_rstest  (dec_rstest)
    );

    always_comb begin
        loc_ok   = (req_loc == active_loc);
        dat_ok   = data_wr && loc_ok && (q.state == ST_READY || q.state == ST_RECV);
        store_w  = dat_ok && (q.state == ST_READY || q.sts[B_EXPECT])
                   && (q.wr_cnt < CNT_W'(CMD_MAX));
        rd_ok    = data_rd && loc_ok && (q.state == ST_DONE) && q.sts[B_AVAIL];
        cr_take  = dec_cmdrdy && (q.state == ST_IDLE || q.state == ST_RECV
                                  || q.state == ST_DONE);
        rsp_take = rsp_ready && (q.state == ST_EXEC);
        cnt_inc  = q.wr_cnt + CNT_W'(1);
    end

    tpm_hdr_len #(.CNT_W(CNT_W)) i_hdr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cr_take || rsp_take),
        .byte_en  (store_w),
        .byte_val (data_wbyte),
        .byte_idx (q.wr_cnt),
        .len_now  (len_now)
    );

    always_comb begin
        rst_val = '0;
        rst_val.state = ST_IDLE;
        rst_val.sts[B_FAM_LO+1:B_FAM_LO] = {1'b0, tpm2_mode};
    end

    always_comb begin
        d        = q;
        d.irq_cr = 1'b0;
        d.irq_sv = 1'b0;
        d.exec   = 1'b0;
        need_irq = 1'b0;

        // command byte stream
        if (dat_ok) begin
            if (q.state == ST_READY) begin
                d.state = ST_RECV;
                d.sts   = sts_merge(d.sts, F_EXPECT | F_VALID);
            end
            if (d.sts[B_EXPECT]) begin
                if (store_w) d.wr_cnt = cnt_inc;
                else         d.sts    = sts_merge(d.sts, F_VALID);
            end
            if (d.sts[B_EXPECT] && (d.wr_cnt >= CNT_W'(HDR_BYTES))) begin
                need_irq = !d.sts[B_VALID];
                if (len_now > 32'(d.wr_cnt)) d.sts = sts_merge(d.sts, F_EXPECT | F_VALID);
                else                         d.sts = sts_merge(d.sts, F_VALID);
                d.irq_sv = need_irq;
            end
        end

        // response consumption
        if (rd_ok) begin
            d.rd_off = q.rd_off + RLEN_W'(1);
            if (d.rd_off >= q.rlen) begin
                d.sts    = sts_merge(d.sts, F_VALID);
                d.irq_sv = 1'b1;
            end
        end

        // status register controls
        if (cr_take) begin
            d.state  = ST_READY;
            d.irq_cr = !q.sts[B_CMDRDY];
            d.sts    = sts_merge(d.sts, F_CMDRDY);
            d.wr_cnt = '0;
            d.rd_off = '0;
        end
        if (dec_go && q.state == ST_RECV && !q.sts[B_EXPECT]) begin
            d.state = ST_EXEC;
            d.exec  = 1'b1;
        end
        if (dec_retry && q.state == ST_DONE) begin
            d.rd_off = '0;
            d.sts    = sts_merge(d.sts, F_VALID | F_AVAIL);
        end
        d.cancel = dec_cancel;
        d.rstest = dec_rstest;

        // engine events
        if (rsp_take) begin
            d.state  = ST_DONE;
            d.sts    = sts_merge(d.sts, F_VALID | F_AVAIL);
            d.rd_off = '0;
            d.wr_cnt = '0;
            d.rlen   = rsp_len;
        end
        if (selftest_done) d.sts[B_STDONE] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= rst_val;
        else        q <= d;
    end

    assign sts           = q.sts;
    assign state         = q.state;
    assign irq_cmd_ready = q.irq_cr;
    assign irq_sts_valid = q.irq_sv;
    assign exec_req      = q.exec;
    assign cancel_req    = q.cancel;
    assign rst_est_req   = q.rstest;

    // R1
    state_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.state <= ST_DONE);
    // R3
    cr_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cmd_ready |-> (state == 3'd1) && sts[B_CMDRDY]);
    // R6
    exec_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        exec_req |-> (state == 3'd3) && ($past(state) == 3'd2));
    // R8
    sv_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_sts_valid |-> sts[B_VALID] && !sts[B_AVAIL]);
    // R10
    sticky_stdone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sts[B_STDONE])) |-> sts[B_STDONE]);
    // R11
    family_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(sts[B_FAM_LO+1:B_FAM_LO]));
    // R12
    cancel_family_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cancel_req |-> (sts[B_FAM_LO+1:B_FAM_LO] == 2'b01));
    // R13
    rstest_loc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_est_req |-> ($past(req_loc) == LOC_W'(3) || $past(req_loc) == LOC_W'(4)));
    // R14
    one_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dec_cmdrdy, dec_go, dec_retry}));

endmodule

// File: tb/test_tpm_loc_seq.sv
module test_tpm_loc_seq;

    localparam int CLK_P = 10;
    localparam int WD_CYC = 20000;
    localparam logic [2:0] OP_STS = 3'd0, OP_DAT = 3'd1, OP_RD = 3'd2,
                           OP_RSP = 3'd3, OP_ST = 3'd4;
    localparam logic [31:0] F2 = 32'h0400_0000;

    typedef struct packed {
        logic [2:0]  op;
        logic [2:0]  loc;
        logic [31:0] arg;
        logic [2:0]  st;
        logic [31:0] sts;
        logic [4:0]  pls;   // {cmd_ready, sts_valid, exec, cancel, rst_est}
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 29;
    localparam vec_t VEC [NV] = '{
        '{OP_STS, 3'd3, 32'h40,        3'd1, F2 | 32'h40, 5'b10000, 4'd3},  // R3
        '{OP_DAT, 3'd3, 32'h80,        3'd2, F2 | 32'h88, 5'b00000, 4'd4},  // R4
        '{OP_DAT, 3'd3, 32'h01,        3'd2, F2 | 32'h88, 5'b00000, 4'd5},  // R5
        '{OP_DAT, 3'd3, 32'h00,        3'd2, F2 | 32'h88, 5'b00000, 4'd5},
        '{OP_DAT, 3'd3, 32'h00,        3'd2, F2 | 32'h88, 5'b00000, 4'd5},
        '{OP_DAT, 3'd3, 32'h00,        3'd2, F2 | 32'h88, 5'b00000, 4'd5},
        '{OP_DAT, 3'd3, 32'h08,        3'd2, F2 | 32'h88, 5'b00000, 4'd5},  // R5 len 8
        '{OP_STS, 3'd3, 32'h20,        3'd2, F2 | 32'h88, 5'b00000, 4'd6},  // R6 early go
        '{OP_DAT, 3'd3, 32'hAA,        3'd2, F2 | 32'h88, 5'b00000, 4'd5},
        '{OP_DAT, 3'd3, 32'hBB,        3'd2, F2 | 32'h80, 5'b00000, 4'd5},  // R5 complete
        '{OP_STS, 3'd2, 32'h20,        3'd2, F2 | 32'h80, 5'b00000, 4'd14}, // R14 other loc
        '{OP_STS, 3'd3, 32'h60,        3'd2, F2 | 32'h80, 5'b00000, 4'd14}, // R14 two bits
        '{OP_ST,  3'd3, 32'h0,         3'd2, F2 | 32'h84, 5'b00000, 4'd10}, // R10
        '{OP_STS, 3'd3, 32'h20,        3'd3, F2 | 32'h84, 5'b00100, 4'd6},  // R6
        '{OP_STS, 3'd3, 32'h0100_0000, 3'd3, F2 | 32'h84, 5'b00010, 4'd12}, // R12
        '{OP_RSP, 3'd3, 32'd3,         3'd4, F2 | 32'h94, 5'b00000, 4'd7},  // R7
        '{OP_RD,  3'd3, 32'h0,         3'd4, F2 | 32'h94, 5'b00000, 4'd8},  // R8
        '{OP_RD,  3'd3, 32'h0,         3'd4, F2 | 32'h94, 5'b00000, 4'd8},
        '{OP_RD,  3'd3, 32'h0,         3'd4, F2 | 32'h84, 5'b01000, 4'd8},
        '{OP_STS, 3'd3, 32'h02,        3'd4, F2 | 32'h94, 5'b00000, 4'd9},  // R9
        '{OP_RD,  3'd3, 32'h0,         3'd4, F2 | 32'h94, 5'b00000, 4'd9},
        '{OP_RD,  3'd3, 32'h0,         3'd4, F2 | 32'h94, 5'b00000, 4'd9},
        '{OP_RD,  3'd3, 32'h0,         3'd4, F2 | 32'h84, 5'b01000, 4'd9},
        '{OP_RD,  3'd3, 32'h0,         3'd4, F2 | 32'h84, 5'b00000, 4'd8},  // R8 extra read
        '{OP_STS, 3'd3, 32'h0100_0000, 3'd4, F2 | 32'h84, 5'b00000, 4'd12}, // R12 not exec
        '{OP_STS, 3'd3, 32'h0200_0000, 3'd4, F2 | 32'h84, 5'b00001, 4'd13}, // R13
        '{OP_RSP, 3'd3, 32'd5,         3'd4, F2 | 32'h84, 5'b00000, 4'd7},  // R7 ignored
        '{OP_STS, 3'd3, 32'h40,        3'd1, F2 | 32'h44, 5'b10000, 4'd2},  // R2 R3 R10
        '{OP_STS, 3'd3, 32'h02,        3'd1, F2 | 32'h44, 5'b00000, 4'd9}   // R9 ignored
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tpm2_mode = 1'b0;
    logic [2:0]  active_loc = 3'd3;
    logic [2:0]  req_loc = 3'd3;
    logic        sts_wr = 1'b0;
    logic [31:0] sts_wdata = '0;
    logic        data_wr = 1'b0;
    logic [7:0]  data_wbyte = '0;
    logic        data_rd = 1'b0;
    logic        rsp_ready = 1'b0;
    logic [15:0] rsp_len = '0;
    logic        selftest_done = 1'b0;
    logic [31:0] sts;
    logic [2:0]  state;
    logic        irq_cmd_ready, irq_sts_valid, exec_req, cancel_req, rst_est_req;
    int          total = 0;
    int          bad = 0;

    always #(CLK_P/2) clk = ~clk;

    tpm_loc_seq i_tpm_loc_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .tpm2_mode     (tpm2_mode),
        .active_loc    (active_loc),
        .req_loc       (req_loc),
        .sts_wr        (sts_wr),
        .sts_wdata     (sts_wdata),
        .data_wr       (data_wr),
        .data_wbyte    (data_wbyte),
        .data_rd       (data_rd),
        .rsp_ready     (rsp_ready),
        .rsp_len       (rsp_len),
        .selftest_done (selftest_done),
        .sts           (sts),
        .state         (state),
        .irq_cmd_ready (irq_cmd_ready),
        .irq_sts_valid (irq_sts_valid),
        .exec_req      (exec_req),
        .cancel_req    (cancel_req),
        .rst_est_req   (rst_est_req)
    );

    task automatic check(input int r, input logic [2:0] est, input logic [31:0] ests,
                         input logic [4:0] epls);
        logic [4:0] pls;
        pls = {irq_cmd_ready, irq_sts_valid, exec_req, cancel_req, rst_est_req};
        total++;
        if (state !== est || sts !== ests || pls !== epls) begin
            bad++;
            $display("FAIL R%0d: state=%0d sts=%h pulses=%b expected state=%0d sts=%h pulses=%b",
                     r, state, sts, pls, est, ests, epls);
        end
    endtask

    task automatic apply(input logic [2:0] op, input logic [2:0] loc, input logic [31:0] arg);
        req_loc = loc;
        case (op)
            OP_STS:  begin sts_wr = 1'b1; sts_wdata = arg; end
            OP_DAT:  begin data_wr = 1'b1; data_wbyte = arg[7:0]; end
            OP_RD:   data_rd = 1'b1;
            OP_RSP:  begin rsp_ready = 1'b1; rsp_len = arg[15:0]; end
            OP_ST:   selftest_done = 1'b1;
            default: ;
        endcase
        @(negedge clk);
        sts_wr = 1'b0; data_wr = 1'b0; data_rd = 1'b0;
        rsp_ready = 1'b0; selftest_done = 1'b0;
    endtask

    task automatic do_reset(input logic fam);
        tpm2_mode = fam;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: all requirements, cycles=%0d expected fewer", WD_CYC);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R1 R11: reset with older family
        do_reset(1'b0);
        check(1, 3'd0, 32'h0, 5'b00000);
        // older family: six-byte command, length 6
        apply(OP_STS, 3'd3, 32'h40);
        apply(OP_DAT, 3'd3, 32'h80);
        apply(OP_DAT, 3'd3, 32'h01);
        apply(OP_DAT, 3'd3, 32'h00);
        apply(OP_DAT, 3'd3, 32'h00);
        apply(OP_DAT, 3'd3, 32'h00);
        apply(OP_DAT, 3'd3, 32'h06);
        check(5, 3'd2, 32'h80, 5'b00000);  // R5 complete at exactly 6 bytes
        apply(OP_STS, 3'd3, 32'h20);
        check(6, 3'd3, 32'h80, 5'b00100);  // R6
        apply(OP_STS, 3'd3, 32'h0100_0000);
        check(12, 3'd3, 32'h80, 5'b00000); // R12 older family no cancel
        apply(OP_STS, 3'd3, 32'h0200_0000);
        check(13, 3'd3, 32'h80, 5'b00000); // R13 older family no request
        apply(OP_ST, 3'd3, 32'h0);
        check(11, 3'd3, 32'h84, 5'b00000); // R11 family stays 00

        // R1 R10 R11: newer family reset clears selftest bit
        do_reset(1'b1);
        check(10, 3'd0, F2, 5'b00000);
        apply(OP_RSP, 3'd3, 32'd4);
        check(7, 3'd0, F2, 5'b00000);      // R7 ignored in IDLE

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i].op, VEC[i].loc, VEC[i].arg);
            check(int'(VEC[i].req), VEC[i].st, VEC[i].sts, VEC[i].pls);
        end

        // R3: command ready during reception
        apply(OP_DAT, 3'd3, 32'h80);
        check(4, 3'd2, F2 | 32'h8C, 5'b00000);
        apply(OP_STS, 3'd3, 32'h40);
        check(3, 3'd1, F2 | 32'h44, 5'b10000);

        // R5: overflow with huge length
        apply(OP_DAT, 3'd3, 32'h80);
        apply(OP_DAT, 3'd3, 32'h01);
        for (int k = 0; k < 4; k++) apply(OP_DAT, 3'd3, 32'hFF);
        check(5, 3'd2, F2 | 32'h8C, 5'b00000);
        for (int k = 0; k < 58; k++) apply(OP_DAT, 3'd3, 32'h00);
        check(5, 3'd2, F2 | 32'h8C, 5'b00000);
        apply(OP_DAT, 3'd3, 32'h00);
        check(5, 3'd2, F2 | 32'h84, 5'b00000);

        // R13: locality 4 allowed, locality 2 refused
        active_loc = 3'd4;
        apply(OP_STS, 3'd4, 32'h0200_0000);
        check(13, 3'd2, F2 | 32'h84, 5'b00001);
        active_loc = 3'd2;
        apply(OP_STS, 3'd2, 32'h0200_0000);
        check(13, 3'd2, F2 | 32'h84, 5'b00000);
        // R14: data byte from other locality in READY leaves state untouched
        apply(OP_STS, 3'd2, 32'h40);
        check(3, 3'd1, F2 | 32'h44, 5'b10000);
        apply(OP_DAT, 3'd3, 32'h80);
        check(14, 3'd1, F2 | 32'h44, 5'b00000);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule